// File: doc/BRIEF.md
# Nested Detour Frame Stack Controller

This controller sits between instruction fetch and decode in a simple in-order core that replaces instructions needing broken hardware with short routines held in a ROM. It tracks which execution context is live. Frame 0 is the program: it fetches from the instruction cache using the main PC and reads the architected registers. Frames 1 and 2 are detour routines. Each of them has a ROM address counter and an auxiliary register file of its own. A routine may itself contain an opcode that has been disabled, and that case opens the second nested level.

Each cycle the controller classifies the presented instruction. An instruction it can run is issued to decode and the live frame's PC steps forward. A disabled opcode opens a new frame. The lower frame keeps the address just past the disabled instruction, the new frame starts at the routine entry address supplied with the fetch, and a copy strobe moves the operands up by exactly one frame. An end marker inside a routine closes that frame. The result moves down by one frame and the lower frame continues from its saved address. If a disabled opcode appears while the deepest frame is live, the controller raises a sticky shutdown and ignores all input until reset. The register file storage and the ROM contents belong to other blocks.

Top module: `xlat_frame_stack`

## Requirements
- R1: After reset, `active_frame` is 0, `fetch_from_rom` is 0, `fetch_addr` equals the `RESET_PC` parameter (default 16'h0100), `shutdown` is 0, and neither `issue_valid` nor `copy_valid` is high.
- R2: When `fetch_valid` is high and the opcode is neither disabled nor a routine end marker, `issue_valid` is high in the same cycle. From the next cycle, `fetch_addr` is the live frame's address plus one and the frame does not change.
- R3: When `fetch_valid` is high, bit `fetch_opcode` of `op_disabled` is 1, and the live frame is below the top frame, `issue_valid` stays low. In the same cycle `copy_valid` is high with `copy_src` = live frame and `copy_dst` = live frame + 1. From the next cycle `active_frame` is one higher, `fetch_from_rom` is 1, and `fetch_addr` equals the zero-extended `route_entry` sampled with the disabled opcode.
- R4: When a frame is closed, the frame below resumes at the address one past the instruction that opened the closed frame.
- R5: In frame 1 or 2, an opcode equal to the `END_OP` parameter (default 4'hF) is not issued. In the same cycle `copy_valid` is high with `copy_src` = live frame and `copy_dst` = live frame - 1. From the next cycle `active_frame` is one lower.
- R6: In frame 0, the `END_OP` opcode is an ordinary instruction. It is issued and advances the main PC.
- R7: Every copy strobe connects two frames whose numbers differ by exactly one.
- R8: A disabled opcode presented while frame 2 (the top of the three frames) is live is not issued and produces no copy. From the next cycle `shutdown` is 1.
- R9: Once `shutdown` is 1, it stays 1 until reset. All further fetches then raise neither `issue_valid` nor `copy_valid`, and they leave `active_frame` and `fetch_addr` unchanged.
- R10: While `fetch_valid` is low, no output strobe is raised and `active_frame` and `fetch_addr` hold.
- R11: `fetch_from_rom` is 1 exactly when `active_frame` is not 0.
- R12: Inside a routine, the end marker wins over the disable mask: `END_OP` closes the frame even when its bit in `op_disabled` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction from the current fetch source is presented |
| fetch_opcode | input | OP_W (4) | Opcode of the presented instruction |
| op_disabled | input | 2**OP_W (16) | One bit per opcode; 1 means that opcode must be detoured |
| route_entry | input | ROM_AW (8) | ROM entry address of the routine for the presented opcode |
| issue_valid | output | 1 | Presented instruction goes on to decode |
| fetch_addr | output | PC_W (16) | Address of the next fetch in the live frame |
| fetch_from_rom | output | 1 | 1: fetch from the routine ROM; 0: from the instruction cache |
| active_frame | output | FR_W (2) | Live frame number; selects the operand register file |
| copy_valid | output | 1 | Operand or result transfer between frames this cycle |
| copy_src | output | FR_W (2) | Frame that supplies the transfer |
| copy_dst | output | FR_W (2) | Frame that receives the transfer |
| shutdown | output | 1 | Sticky fatal stop after a nesting overflow |

## Verification
The hardest state to reach from the ports is the path back out of the deepest frame. The saved addresses of both lower frames have to survive a second push and two pops in sequence, and the overflow has to be provoked while frame 2 is live. The stimulus enables one disabled opcode in the program and a second one inside the first routine. This climbs to frame 2, where it steps and then closes both routines to check both return addresses. Later it climbs again, presents a disabled opcode at the top, and then offers plain, end and disabled opcodes to the halted controller.

// File: rtl/xfs_pkg.sv
package xfs_pkg;
  // Per-cycle outcome of the fetch classifier
  typedef enum logic [2:0] {
    EV_IDLE  = 3'd0,
    EV_PLAIN = 3'd1,
    EV_PUSH  = 3'd2,
    EV_POP   = 3'd3,
    EV_OVF   = 3'd4
  } xfs_ev_t;
endpackage

// File: rtl/xfs_classify.sv
module xfs_classify
  import xfs_pkg::*;
#(
  parameter int OP_W       = 4,
  parameter int MAX_FRAMES = 3,
  parameter logic [OP_W-1:0] END_OP = '1,
  localparam int FR_W  = $clog2(MAX_FRAMES),
  localparam int N_OPS = 1 << OP_W
) (
  input  logic              fetch_valid,
  input  logic [OP_W-1:0]   fetch_opcode,
  input  logic [N_OPS-1:0]  op_disabled,
  input  logic [FR_W-1:0]   active,
  input  logic              halted,
  output xfs_ev_t           ev
);
  localparam logic [FR_W-1:0] TOP_FRAME = FR_W'(MAX_FRAMES - 1);

  // End marker only has meaning inside a routine
  function automatic logic is_end(input logic [OP_W-1:0] op, input logic [FR_W-1:0] fr);
    return (fr != '0) && (op == END_OP);
  endfunction

  always_comb begin
    ev = EV_IDLE;
    if (fetch_valid && !halted) begin
      if (is_end(fetch_opcode, active))
        ev = EV_POP;
      else if (op_disabled[fetch_opcode])
        ev = (active == TOP_FRAME) ? EV_OVF : EV_PUSH;
      else
        ev = EV_PLAIN;
    end
  end
endmodule

// File: rtl/xfs_depth.sv
module xfs_depth
  import xfs_pkg::*;
#(
  parameter int MAX_FRAMES = 3,
  localparam int FR_W = $clog2(MAX_FRAMES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  xfs_ev_t         ev,
  output logic [FR_W-1:0] active,
  output logic            halted
);
  localparam logic [FR_W-1:0] TOP_FRAME = FR_W'(MAX_FRAMES - 1);

  function automatic logic [FR_W-1:0] up(input logic [FR_W-1:0] f);
    return f + FR_W'(1);
  endfunction
  function automatic logic [FR_W-1:0] down(input logic [FR_W-1:0] f);
    return f - FR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
      halted <= 1'b0;
    end else begin
      unique case (ev)
        EV_PUSH: active <= up(active);
        EV_POP:  active <= down(active);
        EV_OVF:  halted <= 1'b1;
        default: ;
      endcase
    end
  end

  // R8
  ovf_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_OVF) |=> halted);
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(active)));
  // R3
  push_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_PUSH) |=> (active == $past(active) + FR_W'(1)));
  // R5
  pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_POP) |=> (active == $past(active) - FR_W'(1)));
  // R3
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active <= TOP_FRAME);
endmodule

// File: rtl/xfs_pc_bank.sv
module xfs_pc_bank
  import xfs_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int ROM_AW     = 8,
  parameter int MAX_FRAMES = 3,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int FR_W = $clog2(MAX_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfs_ev_t           ev,
  input  logic [FR_W-1:0]   active,
  input  logic [ROM_AW-1:0] route_entry,
  output logic [PC_W-1:0]   fetch_addr,
  output logic              fetch_from_rom
);
  logic [PC_W-1:0]   main_pc;
  logic [ROM_AW-1:0] rom_pc [1:MAX_FRAMES-1];

  function automatic logic [PC_W-1:0] main_next(input logic [PC_W-1:0] a);
    return a + PC_W'(1);
  endfunction
  function automatic logic [ROM_AW-1:0] rom_next(input logic [ROM_AW-1:0] a);
    return a + ROM_AW'(1);
  endfunction
  function automatic logic [PC_W-1:0] widen(input logic [ROM_AW-1:0] a);
    return PC_W'(a);
  endfunction

  // The live frame steps on an issued instruction, and on a push (return address)
  logic step_live;
  assign step_live = (ev == EV_PLAIN) || (ev == EV_PUSH);

  always_ff @(posedge clk) begin
    if (!rst_n)
      main_pc <= RESET_PC;
    else if (step_live && active == '0)
      main_pc <= main_next(main_pc);
  end

  for (genvar f = 1; f < MAX_FRAMES; f++) begin : g_rom_frame
    always_ff @(posedge clk) begin
      if (!rst_n)
        rom_pc[f] <= '0;
      else if (ev == EV_PUSH && active == FR_W'(f - 1))
        rom_pc[f] <= route_entry;
      else if (step_live && active == FR_W'(f))
        rom_pc[f] <= rom_next(rom_pc[f]);
    end
  end

  always_comb begin
    fetch_addr     = main_pc;
    fetch_from_rom = 1'b0;
    for (int f = 1; f < MAX_FRAMES; f++) begin
      if (active == FR_W'(f)) begin
        fetch_addr     = widen(rom_pc[f]);
        fetch_from_rom = 1'b1;
      end
    end
  end

  // R2
  main_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_PLAIN && active == '0) |=> (fetch_addr == $past(fetch_addr) + PC_W'(1)));
  // R3
  push_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_PUSH) |=> (fetch_from_rom && fetch_addr == PC_W'($past(route_entry))));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_IDLE) |=> $stable(fetch_addr));
endmodule

// File: rtl/xlat_frame_stack.sv
module xlat_frame_stack
  import xfs_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int ROM_AW     = 8,
  parameter int OP_W       = 4,
  parameter int MAX_FRAMES = 3,
  parameter logic [PC_W-1:0] RESET_PC = 16'h0100,
  parameter logic [OP_W-1:0] END_OP   = 4'hF,
  localparam int FR_W  = $clog2(MAX_FRAMES),
  localparam int N_OPS = 1 << OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [OP_W-1:0]   fetch_opcode,
  input  logic [N_OPS-1:0]  op_disabled,
  input  logic [ROM_AW-1:0] route_entry,
  output logic              issue_valid,
  output logic [PC_W-1:0]   fetch_addr,
  output logic              fetch_from_rom,
  output logic [FR_W-1:0]   active_frame,
  output logic              copy_valid,
  output logic [FR_W-1:0]   copy_src,
  output logic [FR_W-1:0]   copy_dst,
  output logic              shutdown
);
  xfs_ev_t ev;
  logic    halted;

  // Named internal events for the checks
  logic ev_push, ev_pop, ev_ovf;
  assign ev_push = (ev == EV_PUSH);
  assign ev_pop  = (ev == EV_POP);
  assign ev_ovf  = (ev == EV_OVF);

  xfs_classify #(
    .OP_W(OP_W), .MAX_FRAMES(MAX_FRAMES), .END_OP(END_OP)
  ) u_classify (
    .fetch_valid  (fetch_valid),
    .fetch_opcode (fetch_opcode),
    .op_disabled  (op_disabled),
    .active       (active_frame),
    .halted       (halted),
    .ev           (ev)
  );

  xfs_depth #(.MAX_FRAMES(MAX_FRAMES)) u_depth (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev),
    .active (active_frame),
    .halted (halted)
  );

  xfs_pc_bank #(
    .PC_W(PC_W), .ROM_AW(ROM_AW), .MAX_FRAMES(MAX_FRAMES), .RESET_PC(RESET_PC)
  ) u_pc_bank (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev             (ev),
    .active         (active_frame),
    .route_entry    (route_entry),
    .fetch_addr     (fetch_addr),
    .fetch_from_rom (fetch_from_rom)
  );

  assign issue_valid = (ev == EV_PLAIN);
  assign copy_valid  = ev_push || ev_pop;
  assign copy_src    = active_frame;
  assign copy_dst    = ev_pop ? active_frame - FR_W'(1) : active_frame + FR_W'(1);
  assign shutdown    = halted;

  // R7
  neighbour_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_valid |-> ((copy_dst == copy_src + FR_W'(1)) || (copy_src == copy_dst + FR_W'(1))));
  // R11
  rom_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_from_rom == (active_frame != '0));
  // R9
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!issue_valid && !copy_valid));
  // R8
  ovf_no_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |-> (!copy_valid && !issue_valid));
  // R6
  base_end_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !shutdown && active_frame == '0 && fetch_opcode == END_OP
     && !op_disabled[fetch_opcode]) |-> issue_valid);
endmodule

// File: tb/test_xlat_frame_stack.sv
module test_xlat_frame_stack;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [3:0]  fetch_opcode;
  logic [15:0] op_disabled;
  logic [7:0]  route_entry;
  logic        issue_valid;
  logic [15:0] fetch_addr;
  logic        fetch_from_rom;
  logic [1:0]  active_frame;
  logic        copy_valid;
  logic [1:0]  copy_src;
  logic [1:0]  copy_dst;
  logic        shutdown;

  always #5 clk = ~clk;

  xlat_frame_stack i_xlat_frame_stack (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_opcode(fetch_opcode),
    .op_disabled(op_disabled), .route_entry(route_entry), .issue_valid(issue_valid),
    .fetch_addr(fetch_addr), .fetch_from_rom(fetch_from_rom), .active_frame(active_frame),
    .copy_valid(copy_valid), .copy_src(copy_src), .copy_dst(copy_dst), .shutdown(shutdown)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    string       req;
    logic        issue;
    logic        cv;
    logic [1:0]  src;
    logic [1:0]  dst;
    logic [1:0]  frame;
    logic [15:0] addr;
    logic        halt;
  } exp_t;
  exp_t sb[$];

  // Reference model state
  int          m_frame;
  logic [15:0] m_main;
  logic [7:0]  m_rom [3];
  logic        m_halt;

  function automatic logic [15:0] m_addr();
    return (m_frame == 0) ? m_main : {8'h00, m_rom[m_frame]};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_frame = 0; m_main = 16'h0100; m_halt = 0;
    foreach (m_rom[i]) m_rom[i] = 8'h00;
  endtask

  // Driver: applies one fetch and queues what the design must show
  task automatic step(string req, logic v, logic [3:0] op, logic [7:0] entry);
    exp_t e;
    @(negedge clk);
    fetch_valid = v; fetch_opcode = op; route_entry = entry;
    e.req = req; e.issue = 0; e.cv = 0; e.src = 2'(m_frame); e.dst = 0;
    if (v && !m_halt) begin
      if (m_frame != 0 && op == 4'hF) begin
        e.cv = 1; e.dst = 2'(m_frame - 1);
        m_frame--;
      end else if (op_disabled[op]) begin
        if (m_frame == 2) m_halt = 1;
        else begin
          e.cv = 1; e.dst = 2'(m_frame + 1);
          if (m_frame == 0) m_main++; else m_rom[m_frame]++;
          m_frame++;
          m_rom[m_frame] = entry;
        end
      end else begin
        e.issue = 1;
        if (m_frame == 0) m_main++; else m_rom[m_frame]++;
      end
    end
    e.frame = 2'(m_frame); e.addr = m_addr(); e.halt = m_halt;
    #2;
    sb.push_back(e);
  endtask

  // Monitor: compares same-cycle strobes, then post-edge state
  initial begin
    forever begin
      exp_t e;
      wait (sb.size() != 0);
      e = sb.pop_front();
      chk(e.req, "issue_valid", issue_valid, e.issue);
      chk(e.req, "copy_valid", copy_valid, e.cv);
      if (e.cv) begin
        chk(e.req, "copy_src", copy_src, e.src);
        chk(e.req, "copy_dst", copy_dst, e.dst);
      end
      @(posedge clk); #1;
      chk(e.req, "active_frame", active_frame, e.frame);
      chk(e.req, "fetch_addr", fetch_addr, e.addr);
      chk("R11", "fetch_from_rom", fetch_from_rom, e.frame != 0);
      chk(e.req, "shutdown", shutdown, e.halt);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; fetch_valid = 0; fetch_opcode = 0; route_entry = 0; op_disabled = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "active_frame", active_frame, 0);
    chk("R1", "fetch_addr", fetch_addr, 16'h0100);
    chk("R1", "fetch_from_rom", fetch_from_rom, 0);
    chk("R1", "shutdown", shutdown, 0);
    chk("R1", "issue_valid", issue_valid, 0);
    chk("R1", "copy_valid", copy_valid, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    step("R2", 1, 4'h1, 8'h00);
    step("R10", 0, 4'h3, 8'h55);
    step("R6", 1, 4'hF, 8'h00);
    op_disabled = 16'h0008;
    step("R3", 1, 4'h3, 8'h20);
    step("R2", 1, 4'h1, 8'h00);
    op_disabled = 16'h0028;
    step("R3", 1, 4'h5, 8'h40);
    step("R2", 1, 4'h2, 8'h00);
    step("R10", 0, 4'hF, 8'h00);
    step("R4", 1, 4'hF, 8'h00);   // back to frame 1 at 0x22
    step("R4", 1, 4'hF, 8'h00);   // back to frame 0 at 0x0103
    op_disabled = 16'h8008;
    step("R3", 1, 4'h3, 8'h30);
    step("R12", 1, 4'hF, 8'h00);  // end wins over disable bit
    op_disabled = 16'h0028;
    step("R3", 1, 4'h3, 8'h60);
    step("R3", 1, 4'h5, 8'h70);
    step("R8", 1, 4'h3, 8'h90);
    step("R9", 1, 4'h1, 8'h00);
    step("R9", 1, 4'hF, 8'h00);
    step("R9", 1, 4'h5, 8'hA0);
    wait (sb.size() == 0);
    repeat (3) @(negedge clk);
    do_reset();
    step("R2", 1, 4'h0, 8'h00);
    step("R7", 1, 4'h3, 8'h11);
    step("R5", 1, 4'hF, 8'h00);
    wait (sb.size() == 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule